// File: doc/BRIEF.md
# Asynchronous bus termination classifier

This block watches how an asynchronous bus cycle is closed by the responding device. It sees three active-low termination inputs: a two-bit data-size acknowledge, a bus-error line and a halt line. All three are captured only on the falling clock edge. A responder that moves two of them together does so on a rising edge, so both are taken on the same falling-edge sample. A state machine on the rising edge then tracks the order in which the signals show up. That order decides whether the cycle ends as a normal, halt, bus-error or retry termination.

A one-cycle `start` pulse opens a cycle. When the outcome is known, the block raises `done` for one clock and presents three results: the termination type, the acknowledge value captured as port size, and a timeout flag. After the acknowledge has been seen, one further sample is examined, so that a bus error, or a bus error together with halt, can still arrive late. A retry is reported only after bus error has been sampled negated again. A watchdog closes a cycle that nobody answers.

Top module: `bus_term_classifier`

## Requirements
- R1: After a synchronous active-high reset, `done` and `timeout` are 0, `term_type` is 2'b00 and `port_size` is 2'b11.
- R2: While no cycle is open, the termination inputs are ignored. No `done` is produced and `term_type`/`port_size` keep their values.
- R3: An acknowledge, with bus error negated up to and including the sample after it and halt never seen before or with it, gives `term_type` 2'b00 (normal). The acknowledge sample is held in `port_size`, active low: 2'b10 is 8-bit, 2'b01 is 16-bit and 2'b00 is 32-bit.
- R4: Halt seen at any sample up to and including the acknowledge sample, with bus error never asserted, gives `term_type` 2'b01 (halt). This holds even if halt was released before the acknowledge.
- R5: Bus error without halt gives `term_type` 2'b10 (bus error). This applies when bus error comes before the acknowledge, with it, or in the one sample after it. When no acknowledge was sampled, `port_size` reads 2'b11.
- R6: Bus error together with halt (halt present now or seen earlier) gives `term_type` 2'b11 (retry). This applies before, with, or one sample after the acknowledge. `done` is raised only after a sample shows bus error negated.
- R7: The late window is exactly one sample after the acknowledge. Bus error two samples after the acknowledge has no effect, and halt alone after the acknowledge has no effect.
- R8: Inputs are taken only on falling edges. `done` rises on the first rising edge after the falling-edge sample that decides the outcome.
- R9: `done` lasts exactly one cycle. The block then returns to idle and accepts a new `start` on the very next cycle.
- R10: If TIMEOUT_SAMPLES consecutive samples carry neither acknowledge nor bus error, `done` rises with `timeout`=1, `term_type` 2'b00 and `port_size` 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs sampled on its falling edge, state on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a bus cycle for classification |
| ack_n | input | ACK_W | Active-low data-size acknowledge |
| berr_n | input | 1 | Active-low bus error |
| halt_n | input | 1 | Active-low halt |
| done | output | 1 | One-cycle result strobe |
| term_type | output | 2 | 00 normal, 01 halt, 10 bus error, 11 retry |
| port_size | output | ACK_W | Acknowledge value captured at the decision, 11 if none |
| timeout | output | 1 | Set with `done` when the watchdog closed the cycle |

## Verification
The bench sweeps several parameters, each over a small set of values: the acknowledge arrival sample (three values or absent), the bus-error arrival sample and the halt arrival sample (four values or absent each), and all three port sizes. Bus error is released at a fixed later sample. A model in the bench predicts the type, the port size, the timeout flag and the exact sample that decides. Arrival orders where bus error lands before, with, one sample after, or two samples after the acknowledge separate the late window from a single-snapshot decode. Halt placed before, with, or after the acknowledge separates halt from normal and retry from bus error. The retry cases with a late release show whether `done` is held back until bus error clears, and the fully silent cases exercise the watchdog.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  typedef enum logic [1:0] {
    TERM_NORMAL = 2'b00,
    TERM_HALT   = 2'b01,
    TERM_BERR   = 2'b10,
    TERM_RETRY  = 2'b11
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LATE,
    ST_RELEASE
  } state_e;
endpackage

// File: rtl/bus_term_sampler.sv
module bus_term_sampler #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACK_W-1:0] ack_n,
  input  logic             berr_n,
  input  logic             halt_n,
  output logic [ACK_W-1:0] smp_ack_n,
  output logic             smp_berr,
  output logic             smp_halt
);
  // Falling-edge capture: signals moved together on a rising edge land in one sample.
  always_ff @(negedge clk) begin
    if (rst) begin
      smp_ack_n <= '1;
      smp_berr  <= 1'b0;
      smp_halt  <= 1'b0;
    end else begin
      smp_ack_n <= ack_n;
      smp_berr  <= ~berr_n;
      smp_halt  <= ~halt_n;
    end
  end
endmodule

// File: rtl/bus_term_watchdog.sv
module bus_term_watchdog #(
  parameter int TIMEOUT_SAMPLES = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_SAMPLES - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_term_fsm.sv
module bus_term_fsm
  import bus_term_pkg::*;
#(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ACK_W-1:0] smp_ack_n,
  input  logic             smp_berr,
  input  logic             smp_halt,
  input  logic             wd_expired,
  output logic             wd_clear,
  output logic             wd_tick,
  output logic             done,
  output term_e            term_type,
  output logic [ACK_W-1:0] port_size,
  output logic             timeout
);
  state_e state;
  term_e  base_type;
  logic   halt_seen;
  logic   ack_seen;
  logic   halt_any;

  assign ack_seen = (smp_ack_n != '1);
  assign halt_any = smp_halt | halt_seen;
  assign wd_clear = (state == ST_IDLE);
  assign wd_tick  = (state == ST_WAIT) && !smp_berr && !ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      base_type <= TERM_NORMAL;
      halt_seen <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      term_type <= TERM_NORMAL;
      port_size <= '1;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_WAIT;
            halt_seen <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (smp_berr && halt_any) begin
            term_type <= TERM_RETRY;
            port_size <= smp_ack_n;
            state     <= ST_RELEASE;
          end else if (smp_berr) begin
            term_type <= TERM_BERR;
            port_size <= smp_ack_n;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end else if (ack_seen) begin
            base_type <= halt_any ? TERM_HALT : TERM_NORMAL;
            halt_seen <= halt_any;
            port_size <= smp_ack_n;
            state     <= ST_LATE;
          end else begin
            halt_seen <= halt_any;
            if (wd_expired) begin
              term_type <= TERM_NORMAL;
              port_size <= '1;
              timeout   <= 1'b1;
              done      <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_LATE: begin
          if (smp_berr && halt_any) begin
            term_type <= TERM_RETRY;
            state     <= ST_RELEASE;
          end else begin
            term_type <= smp_berr ? TERM_BERR : base_type;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_RELEASE: begin
          if (!smp_berr) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_term_classifier.sv
module bus_term_classifier
  import bus_term_pkg::*;
#(
  parameter int ACK_W           = 2,
  parameter int TIMEOUT_SAMPLES = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ACK_W-1:0] ack_n,
  input  logic             berr_n,
  input  logic             halt_n,
  output logic             done,
  output logic [1:0]       term_type,
  output logic [ACK_W-1:0] port_size,
  output logic             timeout
);
  logic [ACK_W-1:0] smp_ack_n;
  logic             smp_berr;
  logic             smp_halt;
  logic             wd_clear;
  logic             wd_tick;
  logic             wd_expired;
  term_e            type_q;

  bus_term_sampler #(.ACK_W(ACK_W)) u_sampler (
    .clk(clk), .rst(rst), .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n),
    .smp_ack_n(smp_ack_n), .smp_berr(smp_berr), .smp_halt(smp_halt)
  );

  bus_term_watchdog #(.TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)) u_watchdog (
    .clk(clk), .rst(rst), .clear(wd_clear), .tick(wd_tick), .expired(wd_expired)
  );

  bus_term_fsm #(.ACK_W(ACK_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .smp_ack_n(smp_ack_n), .smp_berr(smp_berr), .smp_halt(smp_halt),
    .wd_expired(wd_expired), .wd_clear(wd_clear), .wd_tick(wd_tick),
    .done(done), .term_type(type_q), .port_size(port_size), .timeout(timeout)
  );

  assign term_type = type_q;
endmodule

// File: rtl/bus_term_checker.sv
module bus_term_checker #(
  parameter int ACK_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             timeout,
  input logic [1:0]       term_type,
  input logic [ACK_W-1:0] port_size,
  input logic             berr_act
);
  // R9: result strobe is one cycle wide
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: timeout only with done, normal type and no size
  a_r10_timeout_shape: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (done && term_type == 2'b00 && port_size == '1));

  // R6: a retry is reported only once bus error is sampled released
  a_r6_retry_released: assert property (@(posedge clk) disable iff (rst)
    (done && term_type == 2'b11) |-> !berr_act);

  // R1: first cycle after reset carries no result
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !timeout));
endmodule

bind bus_term_classifier bus_term_checker #(.ACK_W(ACK_W)) u_checker (
  .clk(clk), .rst(rst), .done(done), .timeout(timeout),
  .term_type(term_type), .port_size(port_size), .berr_act(smp_berr)
);

// File: tb/bus_term_classifier_test.sv
`timescale 1ns/100ps
module bus_term_classifier_test;
  localparam int TMO     = 8;
  localparam int REL_IDX = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] ack_n = 2'b11;
  logic       berr_n = 1'b1;
  logic       halt_n = 1'b1;
  logic       done;
  logic [1:0] term_type;
  logic [1:0] port_size;
  logic       timeout;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bus_term_classifier #(.ACK_W(2), .TIMEOUT_SAMPLES(TMO)) uut (
    .clk(clk), .rst(rst), .start(start), .ack_n(ack_n), .berr_n(berr_n),
    .halt_n(halt_n), .done(done), .term_type(term_type),
    .port_size(port_size), .timeout(timeout)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // Stimulus for sample j: a=3 means no ack, b=4 / h=4 means never.
  function automatic void stim(input int j, input int a, input int b, input int h,
                               input logic [1:0] sz, output logic [1:0] ak,
                               output logic be, output logic ha);
    ak = (a < 3 && j >= a) ? sz : 2'b11;
    be = (b < 4 && j >= b && j < REL_IDX);
    ha = (h < 4 && j >= h);
  endfunction

  function automatic void model(input int a, input int b, input int h, input logic [1:0] sz,
                                output int idx, output logic [1:0] ty,
                                output logic [1:0] ps, output logic to);
    int st = 0;
    int cnt = 0;
    logic hs = 1'b0;
    logic [1:0] base = 2'b00;
    logic [1:0] ak;
    logic be, ha;
    idx = -1; ty = 2'b00; ps = 2'b11; to = 1'b0;
    for (int j = 0; j < 40; j++) begin
      stim(j, a, b, h, sz, ak, be, ha);
      if (st == 0) begin
        if (be && (ha || hs)) begin ty = 2'b11; ps = ak; st = 2; end
        else if (be) begin ty = 2'b10; ps = ak; idx = j; return; end
        else if (ak != 2'b11) begin base = (ha || hs) ? 2'b01 : 2'b00; hs = ha || hs; ps = ak; st = 1; end
        else begin
          hs = ha || hs; cnt++;
          if (cnt == TMO) begin ty = 2'b00; ps = 2'b11; to = 1'b1; idx = j; return; end
        end
      end else if (st == 1) begin
        if (be && (ha || hs)) begin ty = 2'b11; st = 2; end
        else begin ty = be ? 2'b10 : base; idx = j; return; end
      end else begin
        if (!be) begin idx = j; return; end
      end
    end
  endfunction

  task automatic run(input int a, input int b, input int h, input logic [1:0] sz, input string force_tag);
    int idx; logic [1:0] ety, eps; logic eto;
    logic [1:0] ak; logic be, ha;
    string tag;
    int seen = -1;
    model(a, b, h, sz, idx, ety, eps, eto);
    if (force_tag != "") tag = force_tag;
    else if (eto) tag = "R10";
    else case (ety)
      2'b00: tag = "R3";
      2'b01: tag = "R4";
      2'b10: tag = "R5";
      default: tag = "R6";
    endcase
    start = 1'b1;
    @(posedge clk); #1;
    chk("R9", "no done at cycle open", int'(done), 0);
    start = 1'b0;
    stim(0, a, b, h, sz, ak, be, ha);
    ack_n = ak; berr_n = ~be; halt_n = ~ha;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      if (done) begin seen = k; break; end
      stim(k + 1, a, b, h, sz, ak, be, ha);
      ack_n = ak; berr_n = ~be; halt_n = ~ha;
    end
    chk("R8", $sformatf("decision sample a%0d b%0d h%0d", a, b, h), seen, idx);
    chk(tag, "term_type", int'(term_type), int'(ety));
    chk(tag, "port_size", int'(port_size), int'(eps));
    chk(tag, "timeout", int'(timeout), int'(eto));
    ack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1;
  endtask

  initial begin
    logic [1:0] sizes [3];
    sizes[0] = 2'b10; sizes[1] = 2'b01; sizes[2] = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "timeout after reset", int'(timeout), 0);
    chk("R1", "term_type after reset", int'(term_type), 0);
    chk("R1", "port_size after reset", int'(port_size), 3);

    // R2: termination inputs without start
    ack_n = 2'b00; berr_n = 1'b0; halt_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk("R2", "done while idle", int'(done), 0);
    end
    chk("R2", "term_type kept", int'(term_type), 0);
    chk("R2", "port_size kept", int'(port_size), 3);
    ack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1;
    @(posedge clk); #1;

    // R7 directed: window is one sample
    run(0, 2, 4, 2'b00, "R7");
    run(0, 4, 1, 2'b01, "R7");
    run(0, 1, 4, 2'b10, "R7");
    run(1, 2, 2, 2'b00, "R7");

    // Sweep of arrival orders and sizes
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 5; b++)
          for (int h = 0; h < 5; h++)
            run(a, b, h, sizes[s], "");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule